// File: doc/BRIEF.md
# Multi-Window Event and Semaphore Register File

This block keeps a bank of single-bit events and a bank of 32-bit unsigned counting semaphores behind a 20-bit, 32-bit-wide address space. Software reaches it through an APB slave port. A second, write-only port lets an on-chip bus master post updates into the same storage. Each semaphore is visible through several address aliases. The alias that an access hits picks the operation: read the live count, overwrite it, add a delta or subtract a delta. The block performs every add and subtract internally, so two writers that post to one counter can never lose an update.

Each accepted change is reported on one of two one-cycle update lanes. Lane 0 carries changes made from APB and lane 1 carries changes made from the bus master. Each report holds the entry index, whether the entry is a semaphore, the old and new values and an operation code. Downstream notification logic uses these reports. Threshold comparison and address routing beyond the 20-bit window belong to other blocks.

Top module: `evsem_regfile`

## Requirements
- R1: After a synchronous active-high reset, every event and every counter reads zero and neither update lane is valid. `pready` is always 1 and `pslverr` is always 0.
- R2: The event window sits at byte offset 0x0000 + 4·N. A write copies bit 0 of the data into event N: 1 sets it and 0 clears it. A read returns the event state in bit 0, with bits 31:1 zero.
- R3: The count window sits at 0x1000 + 4·N. It is read-only and returns the current 32-bit count of semaphore N.
- R4: The overwrite window sits at 0x1400 + 4·N. Writing there replaces the count with the written word.
- R5: The add window sits at 0x1800 + 4·N and the subtract window at 0x1C00 + 4·N. Writing there adds the word to, or subtracts it from, the count, modulo 2^32.
- R6: The following accesses are ignored and raise no update: writes to the count window, writes to reserved space (0x0400–0x0FFF and 0x2000–0xFFFFF), and writes to entries beyond the configured count. Reads of the overwrite, add and subtract windows and of reserved space return zero.
- R7: A master-port write (`mst_valid` high for one cycle) decodes the same windows and has the same effect as the equivalent APB write.
- R8: When both ports post an add or a subtract to the same semaphore in one cycle, both deltas are applied in that cycle.
- R9: On a same-cycle collision at one semaphore, an overwrite from either port beats any delta. An APB overwrite beats a master overwrite. On a same-cycle collision at one event, the APB write wins.
- R10: In the cycle after an accepted write, the lane of the writing port pulses valid for one cycle. The report carries the index, the is-semaphore flag, the old and new values and an op code: 0 event set, 1 event clear, 2 overwrite, 3 add, 4 subtract, 5 merged. A same-semaphore collision is reported once, on lane 0 with op 5, and lane 1 stays silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 20 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, captured in the setup phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| mst_valid | input | 1 | Master-port write strobe |
| mst_addr | input | 20 | Master-port byte address |
| mst_data | input | 32 | Master-port write data |
| upd0_valid | output | 1 | APB-side update pulse |
| upd0_index | output | 8 | Entry index of the lane 0 report |
| upd0_is_sem | output | 1 | Lane 0 report concerns a semaphore |
| upd0_op | output | 3 | Lane 0 op code |
| upd0_old | output | 32 | Value before the lane 0 change |
| upd0_new | output | 32 | Value after the lane 0 change |
| upd1_valid | output | 1 | Master-side update pulse |
| upd1_index | output | 8 | Entry index of the lane 1 report |
| upd1_is_sem | output | 1 | Lane 1 report concerns a semaphore |
| upd1_op | output | 3 | Lane 1 op code |
| upd1_old | output | 32 | Value before the lane 1 change |
| upd1_new | output | 32 | Value after the lane 1 change |

## Verification
The bench drives both ports in the same cycle at one counter with these pairings: two adds, an add with a subtract, an overwrite against a delta, and two overwrites. A design that kept only one write would lose a delta or let the wrong overwrite win. It also checks that a collision yields one merged report and not two. Counts are pushed across zero and across 2^32 to catch missing wraparound. Writes land on reserved space and on the read-only alias, which a sloppy decoder would fold onto a live counter. Reads of the write-only windows must return zero rather than the count.

// File: rtl/evsem_pkg.sv
package evsem_pkg;
  // Operation codes reported on the update lanes.
  typedef enum logic [2:0] {
    OP_EVT_SET    = 3'd0,
    OP_EVT_CLR    = 3'd1,
    OP_SEM_SET    = 3'd2,
    OP_SEM_INC    = 3'd3,
    OP_SEM_DEC    = 3'd4,
    OP_SEM_MERGED = 3'd5
  } evsem_op_e;

  // Which alias an address falls into.
  typedef enum logic [2:0] {
    WIN_EVENT,
    WIN_COUNT,
    WIN_SET,
    WIN_ADD,
    WIN_SUB,
    WIN_NONE
  } evsem_win_e;

  // Each alias spans 1 KiB; the alias selector occupies bits [12:10].
  localparam int WIN_LSB    = 10;
  localparam int REGION_LSB = 13;
endpackage

// File: rtl/evsem_decode.sv
module evsem_decode
  import evsem_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int NUM_ENTRIES = 256,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic [ADDR_W-1:0] addr,
  output evsem_win_e        win,
  output logic [IDX_W-1:0]  idx
);
  localparam int SLOT_W = WIN_LSB - 2;

  logic [SLOT_W-1:0] slot;
  logic              in_range;
  logic              upper_clear;
  logic [1:0]        unused_byte;

  assign unused_byte = addr[1:0];
  assign slot        = addr[WIN_LSB-1:2];
  assign idx         = addr[IDX_W+1:2];
  assign in_range    = ({1'b0, slot} < (SLOT_W+1)'(NUM_ENTRIES));
  assign upper_clear = (addr[ADDR_W-1:REGION_LSB] == '0);

  always_comb begin
    win = WIN_NONE;
    if (upper_clear && in_range) begin
      case (addr[REGION_LSB-1:WIN_LSB])
        3'b000:  win = WIN_EVENT;
        3'b100:  win = WIN_COUNT;
        3'b101:  win = WIN_SET;
        3'b110:  win = WIN_ADD;
        3'b111:  win = WIN_SUB;
        default: win = WIN_NONE;
      endcase
    end
  end
endmodule

// File: rtl/evsem_sem_bank.sv
module evsem_sem_bank
  import evsem_pkg::*;
#(
  parameter int NUM_ENTRIES = 256,
  parameter int DATA_W      = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_we,
  input  evsem_op_e         a_op,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_we,
  input  evsem_op_e         b_op,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [DATA_W-1:0] b_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              u0_valid,
  output logic [IDX_W-1:0]  u0_idx,
  output evsem_op_e         u0_op,
  output logic [DATA_W-1:0] u0_old,
  output logic [DATA_W-1:0] u0_new,
  output logic              u1_valid,
  output logic [IDX_W-1:0]  u1_idx,
  output evsem_op_e         u1_op,
  output logic [DATA_W-1:0] u1_old,
  output logic [DATA_W-1:0] u1_new
);
  logic [DATA_W-1:0] cnt [NUM_ENTRIES];
  logic [DATA_W-1:0] old_a, old_b, new_a, new_b;
  logic              same;

  function automatic logic [DATA_W-1:0] delta_of(evsem_op_e op, logic [DATA_W-1:0] d);
    case (op)
      OP_SEM_INC: delta_of = d;
      OP_SEM_DEC: delta_of = '0 - d;
      default:    delta_of = '0;
    endcase
  endfunction

  assign old_a   = cnt[a_idx];
  assign old_b   = cnt[b_idx];
  assign rd_data = cnt[rd_idx];
  assign same    = a_we && b_we && (a_idx == b_idx);

  always_comb begin
    new_b = (b_op == OP_SEM_SET) ? b_data : old_b + delta_of(b_op, b_data);
    if (same) begin
      if (a_op == OP_SEM_SET)      new_a = a_data;
      else if (b_op == OP_SEM_SET) new_a = b_data;
      else                         new_a = old_a + delta_of(a_op, a_data) + delta_of(b_op, b_data);
    end else begin
      new_a = (a_op == OP_SEM_SET) ? a_data : old_a + delta_of(a_op, a_data);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ENTRIES; i++) cnt[i] <= '0;
    end else begin
      if (b_we && !same) cnt[b_idx] <= new_b;
      if (a_we)          cnt[a_idx] <= new_a;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      u0_valid <= 1'b0;
      u0_idx   <= '0;
      u0_op    <= OP_EVT_SET;
      u0_old   <= '0;
      u0_new   <= '0;
      u1_valid <= 1'b0;
      u1_idx   <= '0;
      u1_op    <= OP_EVT_SET;
      u1_old   <= '0;
      u1_new   <= '0;
    end else begin
      u0_valid <= a_we;
      u0_idx   <= a_idx;
      u0_op    <= same ? OP_SEM_MERGED : a_op;
      u0_old   <= old_a;
      u0_new   <= new_a;
      u1_valid <= b_we && !same;
      u1_idx   <= b_idx;
      u1_op    <= b_op;
      u1_old   <= old_b;
      u1_new   <= new_b;
    end
  end

  // R8: a collision is reported once, never on both lanes at one index
  p_single_report_r8: assert property (@(posedge clk) disable iff (rst)
    u1_valid |-> !(u0_valid && (u0_idx == u1_idx)));

  // R9: an APB overwrite in a collision lands unchanged
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (a_we && b_we && (a_idx == b_idx) && a_op == OP_SEM_SET) |=> (u0_new == $past(a_data)));

  // R5: a lone APB add moves the count by exactly the delta
  p_add_delta_r5: assert property (@(posedge clk) disable iff (rst)
    (a_we && !b_we && a_op == OP_SEM_INC) |=> (u0_new == u0_old + $past(a_data)));
endmodule

// File: rtl/evsem_evt_bank.sv
module evsem_evt_bank #(
  parameter int NUM_ENTRIES = 256,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_we,
  input  logic [IDX_W-1:0] a_idx,
  input  logic             a_val,
  input  logic             b_we,
  input  logic [IDX_W-1:0] b_idx,
  input  logic             b_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit,
  output logic             e0_valid,
  output logic [IDX_W-1:0] e0_idx,
  output logic             e0_old,
  output logic             e0_new,
  output logic             e1_valid,
  output logic [IDX_W-1:0] e1_idx,
  output logic             e1_old,
  output logic             e1_new
);
  logic [NUM_ENTRIES-1:0] flag;
  logic                   clash;

  assign clash  = a_we && b_we && (a_idx == b_idx);
  assign rd_bit = flag[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= '0;
    end else begin
      if (b_we && !clash) flag[b_idx] <= b_val;
      if (a_we)           flag[a_idx] <= a_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e0_valid <= 1'b0;
      e0_idx   <= '0;
      e0_old   <= 1'b0;
      e0_new   <= 1'b0;
      e1_valid <= 1'b0;
      e1_idx   <= '0;
      e1_old   <= 1'b0;
      e1_new   <= 1'b0;
    end else begin
      e0_valid <= a_we;
      e0_idx   <= a_idx;
      e0_old   <= flag[a_idx];
      e0_new   <= a_val;
      e1_valid <= b_we && !clash;
      e1_idx   <= b_idx;
      e1_old   <= flag[b_idx];
      e1_new   <= b_val;
    end
  end

  // R2: the written bit is what the event holds afterwards
  p_evt_holds_r2: assert property (@(posedge clk) disable iff (rst)
    a_we |=> (flag[$past(a_idx)] == $past(a_val)));

  // R9: the master loses an event clash, so lane 1 stays quiet
  p_evt_clash_r9: assert property (@(posedge clk) disable iff (rst)
    (a_we && b_we && (a_idx == b_idx)) |=> !e1_valid);
endmodule

// File: rtl/evsem_regfile.sv
module evsem_regfile
  import evsem_pkg::*;
#(
  parameter int NUM_ENTRIES = 256,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 20,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              mst_valid,
  input  logic [ADDR_W-1:0] mst_addr,
  input  logic [DATA_W-1:0] mst_data,
  output logic              upd0_valid,
  output logic [IDX_W-1:0]  upd0_index,
  output logic              upd0_is_sem,
  output logic [2:0]        upd0_op,
  output logic [DATA_W-1:0] upd0_old,
  output logic [DATA_W-1:0] upd0_new,
  output logic              upd1_valid,
  output logic [IDX_W-1:0]  upd1_index,
  output logic              upd1_is_sem,
  output logic [2:0]        upd1_op,
  output logic [DATA_W-1:0] upd1_old,
  output logic [DATA_W-1:0] upd1_new
);
  evsem_win_e       a_win, b_win;
  logic [IDX_W-1:0] a_idx, b_idx;
  logic             apb_wr, apb_rd_setup;
  logic             a_sem_we, b_sem_we, a_evt_we, b_evt_we;
  evsem_op_e        a_op, b_op;

  evsem_decode #(.ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES)) u_dec_apb (
    .addr(paddr), .win(a_win), .idx(a_idx));
  evsem_decode #(.ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES)) u_dec_mst (
    .addr(mst_addr), .win(b_win), .idx(b_idx));

  function automatic evsem_op_e op_of(evsem_win_e w);
    case (w)
      WIN_SET: op_of = OP_SEM_SET;
      WIN_ADD: op_of = OP_SEM_INC;
      WIN_SUB: op_of = OP_SEM_DEC;
      default: op_of = OP_EVT_SET;
    endcase
  endfunction

  function automatic logic is_sem_write(evsem_win_e w);
    is_sem_write = (w == WIN_SET) || (w == WIN_ADD) || (w == WIN_SUB);
  endfunction

  assign apb_wr       = psel && penable && pwrite;
  assign apb_rd_setup = psel && !penable && !pwrite;
  assign a_sem_we     = apb_wr && is_sem_write(a_win);
  assign b_sem_we     = mst_valid && is_sem_write(b_win);
  assign a_evt_we     = apb_wr && (a_win == WIN_EVENT);
  assign b_evt_we     = mst_valid && (b_win == WIN_EVENT);
  assign a_op         = op_of(a_win);
  assign b_op         = op_of(b_win);
  assign pready       = 1'b1;
  assign pslverr      = 1'b0;

  logic [DATA_W-1:0] sem_rd;
  logic              evt_rd;
  logic              s0_v, s1_v, e0_v, e1_v;
  logic [IDX_W-1:0]  s0_i, s1_i, e0_i, e1_i;
  evsem_op_e         s0_op, s1_op;
  logic [DATA_W-1:0] s0_o, s0_n, s1_o, s1_n;
  logic              e0_o, e0_n, e1_o, e1_n;

  evsem_sem_bank #(.NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W)) u_sem (
    .clk(clk), .rst(rst),
    .a_we(a_sem_we), .a_op(a_op), .a_idx(a_idx), .a_data(pwdata),
    .b_we(b_sem_we), .b_op(b_op), .b_idx(b_idx), .b_data(mst_data),
    .rd_idx(a_idx), .rd_data(sem_rd),
    .u0_valid(s0_v), .u0_idx(s0_i), .u0_op(s0_op), .u0_old(s0_o), .u0_new(s0_n),
    .u1_valid(s1_v), .u1_idx(s1_i), .u1_op(s1_op), .u1_old(s1_o), .u1_new(s1_n));

  evsem_evt_bank #(.NUM_ENTRIES(NUM_ENTRIES)) u_evt (
    .clk(clk), .rst(rst),
    .a_we(a_evt_we), .a_idx(a_idx), .a_val(pwdata[0]),
    .b_we(b_evt_we), .b_idx(b_idx), .b_val(mst_data[0]),
    .rd_idx(a_idx), .rd_bit(evt_rd),
    .e0_valid(e0_v), .e0_idx(e0_i), .e0_old(e0_o), .e0_new(e0_n),
    .e1_valid(e1_v), .e1_idx(e1_i), .e1_old(e1_o), .e1_new(e1_n));

  // Read data is captured in the setup phase and held for the access phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      prdata <= '0;
    end else if (apb_rd_setup) begin
      case (a_win)
        WIN_EVENT: prdata <= {{(DATA_W-1){1'b0}}, evt_rd};
        WIN_COUNT: prdata <= sem_rd;
        default:   prdata <= '0;
      endcase
    end
  end

  // A port writes either one event or one semaphore per cycle, never both.
  assign upd0_valid  = s0_v || e0_v;
  assign upd0_is_sem = s0_v;
  assign upd0_index  = s0_v ? s0_i : e0_i;
  assign upd0_op     = s0_v ? s0_op : (e0_n ? OP_EVT_SET : OP_EVT_CLR);
  assign upd0_old    = s0_v ? s0_o : {{(DATA_W-1){1'b0}}, e0_o};
  assign upd0_new    = s0_v ? s0_n : {{(DATA_W-1){1'b0}}, e0_n};
  assign upd1_valid  = s1_v || e1_v;
  assign upd1_is_sem = s1_v;
  assign upd1_index  = s1_v ? s1_i : e1_i;
  assign upd1_op     = s1_v ? s1_op : (e1_n ? OP_EVT_SET : OP_EVT_CLR);
  assign upd1_old    = s1_v ? s1_o : {{(DATA_W-1){1'b0}}, e1_o};
  assign upd1_new    = s1_v ? s1_n : {{(DATA_W-1){1'b0}}, e1_n};

  // R6: writes to reserved space raise no update
  p_reserved_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (apb_wr && (a_win == WIN_NONE || a_win == WIN_COUNT)) |=> !upd0_valid);

  // R6: reads of write-only and reserved space return zero
  p_wo_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (apb_rd_setup && !(a_win == WIN_EVENT || a_win == WIN_COUNT)) |=> (prdata == '0));

  // R10: an update lane pulse always follows a write on its own port
  p_lane0_cause_r10: assert property (@(posedge clk) disable iff (rst)
    upd0_valid |-> $past(apb_wr));
  p_lane1_cause_r10: assert property (@(posedge clk) disable iff (rst)
    upd1_valid |-> $past(mst_valid));
endmodule

// File: tb/evsem_regfile_tb.sv
module evsem_regfile_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [19:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        mst_valid = 1'b0;
  logic [19:0] mst_addr = '0;
  logic [31:0] mst_data = '0;
  logic        upd0_valid, upd0_is_sem, upd1_valid, upd1_is_sem;
  logic [7:0]  upd0_index, upd1_index;
  logic [2:0]  upd0_op, upd1_op;
  logic [31:0] upd0_old, upd0_new, upd1_old, upd1_new;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evsem_regfile u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .mst_valid(mst_valid), .mst_addr(mst_addr), .mst_data(mst_data),
    .upd0_valid(upd0_valid), .upd0_index(upd0_index), .upd0_is_sem(upd0_is_sem),
    .upd0_op(upd0_op), .upd0_old(upd0_old), .upd0_new(upd0_new),
    .upd1_valid(upd1_valid), .upd1_index(upd1_index), .upd1_is_sem(upd1_is_sem),
    .upd1_op(upd1_op), .upd1_old(upd1_old), .upd1_new(upd1_new));

  // {write, address, data-or-expected}; covers R2 R3 R4 R5 R6
  localparam int NV = 23;
  localparam logic [52:0] VEC [0:NV-1] = '{
    {1'b1, 20'h01414, 32'h00000064},
    {1'b0, 20'h01014, 32'h00000064},
    {1'b1, 20'h01814, 32'h00000017},
    {1'b0, 20'h01014, 32'h0000007B},
    {1'b1, 20'h01C14, 32'h000000C8},
    {1'b0, 20'h01014, 32'hFFFFFFB3},
    {1'b1, 20'h01814, 32'h00000050},
    {1'b0, 20'h01014, 32'h00000003},
    {1'b1, 20'h00008, 32'hFFFFFFFF},
    {1'b0, 20'h00008, 32'h00000001},
    {1'b0, 20'h0000C, 32'h00000000},
    {1'b1, 20'h00008, 32'hFFFFFFFE},
    {1'b0, 20'h00008, 32'h00000000},
    {1'b0, 20'h01814, 32'h00000000},
    {1'b0, 20'h01414, 32'h00000000},
    {1'b1, 20'h00500, 32'h00000007},
    {1'b0, 20'h00500, 32'h00000000},
    {1'b1, 20'h02014, 32'h00000009},
    {1'b0, 20'h01014, 32'h00000003},
    {1'b1, 20'h017FC, 32'hDEADBEEF},
    {1'b0, 20'h013FC, 32'hDEADBEEF},
    {1'b1, 20'h01C00, 32'h00000001},
    {1'b0, 20'h01000, 32'hFFFFFFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [19:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic mst_wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk); mst_valid = 1; mst_addr = a; mst_data = d;
    @(negedge clk); mst_valid = 0;
  endtask

  task automatic both_wr(input logic [19:0] aa, input logic [31:0] ad,
                         input logic [19:0] ma, input logic [31:0] md);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = aa; pwdata = ad;
    @(negedge clk); penable = 1; mst_valid = 1; mst_addr = ma; mst_data = md;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; mst_valid = 0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    chk("R1 pready", {31'b0, pready}, 32'd1);
    chk("R1 pslverr", {31'b0, pslverr}, 32'd0);
    chk("R1 lane0 idle", {31'b0, upd0_valid}, 32'd0);
    chk("R1 lane1 idle", {31'b0, upd1_valid}, 32'd0);
    apb_rd(20'h0101C, r); chk("R1 count zero", r, 32'd0);
    apb_rd(20'h0001C, r); chk("R1 event zero", r, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][52]) apb_wr(VEC[i][51:32], VEC[i][31:0]);
      else begin
        apb_rd(VEC[i][51:32], r);
        chk($sformatf("R2-R6 vector %0d", i), r, VEC[i][31:0]);
      end
    end

    // R7 R10: master-only add on semaphore 8
    mst_wr(20'h01820, 32'd5);
    chk("R10 lane1 valid", {31'b0, upd1_valid}, 32'd1);
    chk("R10 lane1 index", {24'b0, upd1_index}, 32'd8);
    chk("R10 lane1 op add", {29'b0, upd1_op}, 32'd3);
    chk("R10 lane1 old", upd1_old, 32'd0);
    chk("R10 lane1 new", upd1_new, 32'd5);
    chk("R10 lane1 is_sem", {31'b0, upd1_is_sem}, 32'd1);
    chk("R10 lane0 quiet", {31'b0, upd0_valid}, 32'd0);
    apb_rd(20'h01020, r); chk("R7 master add", r, 32'd5);

    // R8: both ports add to one counter
    both_wr(20'h01820, 32'd10, 20'h01820, 32'd7);
    chk("R10 merged lane0 valid", {31'b0, upd0_valid}, 32'd1);
    chk("R10 merged op", {29'b0, upd0_op}, 32'd5);
    chk("R10 merged old", upd0_old, 32'd5);
    chk("R10 merged new", upd0_new, 32'd22);
    chk("R8 lane1 silent", {31'b0, upd1_valid}, 32'd0);
    apb_rd(20'h01020, r); chk("R8 add+add", r, 32'd22);
    both_wr(20'h01C20, 32'd2, 20'h01820, 32'd100);
    apb_rd(20'h01020, r); chk("R8 sub+add", r, 32'd120);

    // R9: overwrite precedence
    both_wr(20'h01820, 32'd1, 20'h01420, 32'd50);
    apb_rd(20'h01020, r); chk("R9 master set beats add", r, 32'd50);
    both_wr(20'h01420, 32'd9, 20'h01420, 32'd77);
    apb_rd(20'h01020, r); chk("R9 apb set beats master set", r, 32'd9);
    both_wr(20'h01420, 32'd1000, 20'h01820, 32'd3);
    apb_rd(20'h01020, r); chk("R9 apb set beats add", r, 32'd1000);
    both_wr(20'h00040, 32'd1, 20'h00040, 32'd0);
    apb_rd(20'h00040, r); chk("R9 apb wins event clash", r, 32'd1);

    // R7 R10: different counters in one cycle
    both_wr(20'h01424, 32'd4, 20'h01828, 32'd6);
    chk("R10 lane0 index", {24'b0, upd0_index}, 32'd9);
    chk("R10 lane0 op set", {29'b0, upd0_op}, 32'd2);
    chk("R10 lane1 both valid", {31'b0, upd1_valid}, 32'd1);
    chk("R10 lane1 index 10", {24'b0, upd1_index}, 32'd10);
    apb_rd(20'h01024, r); chk("R7 sem9", r, 32'd4);
    apb_rd(20'h01028, r); chk("R7 sem10", r, 32'd6);

    // R10 R2 R7: event reports
    apb_wr(20'h00010, 32'd1);
    chk("R10 event is_sem", {31'b0, upd0_is_sem}, 32'd0);
    chk("R10 event op set", {29'b0, upd0_op}, 32'd0);
    chk("R10 event new", upd0_new, 32'd1);
    chk("R10 event index", {24'b0, upd0_index}, 32'd4);
    mst_wr(20'h00010, 32'd0);
    chk("R10 event op clear", {29'b0, upd1_op}, 32'd1);
    apb_rd(20'h00010, r); chk("R7 master clears event", r, 32'd0);

    // R6: ignored writes
    apb_wr(20'h00600, 32'd5);
    chk("R6 reserved no update", {31'b0, upd0_valid}, 32'd0);
    apb_wr(20'h01024, 32'd77);
    chk("R6 count window no update", {31'b0, upd0_valid}, 32'd0);
    apb_rd(20'h01024, r); chk("R6 count window unchanged", r, 32'd4);
    mst_wr(20'h02028, 32'd1);
    chk("R6 master reserved no update", {31'b0, upd1_valid}, 32'd0);
    apb_rd(20'h01028, r); chk("R6 sem10 unchanged", r, 32'd6);

    // R1: reset in mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    apb_rd(20'h01020, r); chk("R1 reset clears sem8", r, 32'd0);
    apb_rd(20'h013FC, r); chk("R1 reset clears sem255", r, 32'd0);

    summary();
  end
endmodule